// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block drives the blanking strobe of an interlaced video encoder whose core clock runs at twice the pixel rate. A single-cycle sync reference pulse marks the zero point of each scan line, 32 double-rate clocks ahead of the midpoint of the composite sync. From that point a horizontal pixel counter advances once every two clocks. Software-programmed start and end counts bound the active part of each line. Start and end line numbers select which lines of a field are blanked from edge to edge.

The block also keeps a line counter. The counter steps on every sync reference pulse and wraps at a programmable lines-per-field value, and a field flag flips on each wrap. An edge select input chooses one of two timings for the strobe. With the select cleared the strobe opens active video one pixel clock earlier than it does with the select set, so the pixel source can present data either one pixel clock after the strobe or in the same cycle.

The strobe is active low: `blank_n` low means blanking is in force, and high means pixel data is used. Total and active pixel counts per line are expected to be even, and multiples of four when the input bus carries multiplexed 8-bit samples. The block does not check this.

Top module: `blank_timing_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first sync reference pulse, `blank_n` is 0, `line_num` is 0 and `field` is 0.
- R2: The horizontal count is 0 in the two clocks that follow a `sync_ref` pulse and rises by one every second clock after that. The count after edge m (edge 0 being the one that samples `sync_ref`) is floor(m/2).
- R3: With `edge_sel` = 0 and `h_start` < `h_end` on a line that is not vertically blanked, `blank_n` rises one clock after the horizontal count first equals `h_start`. That is the sample taken after edge 2·`h_start`+1.
- R4: Under the same conditions, `blank_n` falls one clock after the horizontal count first equals `h_end` and stays low for the rest of the line.
- R5: If `h_start` >= `h_end`, `blank_n` stays 0 for the whole line.
- R6: When `v_start` < `v_end`, lines whose `line_num` satisfies `v_start` <= `line_num` < `v_end` are blanked for their entire length.
- R7: When `v_start` > `v_end`, the blanked range wraps through the field boundary. Lines with `line_num` >= `v_start` or `line_num` < `v_end` are blanked.
- R8: With `edge_sel` = 1, both edges of `blank_n` occur two double-rate clocks (one pixel clock) later than with `edge_sel` = 0.
- R9: Each `sync_ref` pulse advances `line_num` by one. From `lines_per_field`−1 it returns to 0 and `field` inverts. Between pulses neither output changes.
- R10: When `v_start` equals `v_end`, no line is vertically blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Double pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_ref | input | 1 | One-cycle pulse at the horizontal zero point |
| edge_sel | input | 1 | 0: strobe one pixel clock ahead of data; 1: strobe aligned with data |
| h_start | input | HW (11) | Horizontal count at which active video begins |
| h_end | input | HW (11) | Horizontal count at which blanking resumes |
| v_start | input | VW (10) | First fully blanked line |
| v_end | input | VW (10) | First line after the blanked range |
| lines_per_field | input | VW (10) | Number of lines in a field |
| blank_n | output | 1 | Blanking strobe, low while blanked |
| line_num | output | VW (10) | Current line within the field |
| field | output | 1 | Field flag, toggles at each field wrap |

## Verification
The hardest case to reach is the wrapping vertical range. There the blanked lines lie at both ends of a field, so they are only seen once the line counter has passed its limit and `field` has flipped. The bench programs a short field of six lines and drives more sync pulses than one field holds. The wrap, the field toggle and both halves of the wrapped range are then all seen within a few lines. Exact edge placement is checked by sampling every clock of each line against a count model that starts from the pulse, for both settings of the edge select.

// File: rtl/blank_pkg.sv
package blank_pkg;

  typedef enum logic {
    EDGE_EARLY = 1'b0,
    EDGE_LATE  = 1'b1
  } edge_mode_e;

  // Number of double-rate clocks per horizontal count step.
  localparam int unsigned CLKS_PER_STEP = 2;

endpackage

// File: rtl/bt_hcount.sv
module bt_hcount #(
  parameter int unsigned HW = 11
) (
  input  logic          clk_2x,
  input  logic          rst_n,
  input  logic          sync_ref,
  output logic [HW-1:0] hcount
);

  logic          ph_q, ph_d;
  logic [HW-1:0] cnt_q, cnt_d;

  // Phase toggles every clock; the count steps on the second clock of
  // each pair and saturates at its maximum if no new line arrives.
  always_comb begin
    ph_d  = ~ph_q;
    cnt_d = cnt_q;
    if (ph_q && (cnt_q != {HW{1'b1}})) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (sync_ref) begin
      ph_d  = 1'b0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= {HW{1'b1}};
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign hcount = cnt_q;

endmodule

// File: rtl/bt_linecnt.sv
module bt_linecnt #(
  parameter int unsigned VW = 10
) (
  input  logic          clk_2x,
  input  logic          rst_n,
  input  logic          sync_ref,
  input  logic [VW-1:0] lines_per_field,
  output logic [VW-1:0] line_num,
  output logic          field
);

  logic [VW-1:0] line_q, line_d;
  logic          field_q, field_d;
  logic [VW-1:0] last_line;
  logic          at_last;

  assign last_line = lines_per_field - 1'b1;
  assign at_last   = (line_q >= last_line);

  always_comb begin
    line_d  = line_q;
    field_d = field_q;
    if (sync_ref) begin
      if (at_last) begin
        line_d  = '0;
        field_d = ~field_q;
      end else begin
        line_d  = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      field_q <= 1'b0;
    end else begin
      line_q  <= line_d;
      field_q <= field_d;
    end
  end

  assign line_num = line_q;
  assign field    = field_q;

endmodule

// File: rtl/bt_decide.sv
module bt_decide
  import blank_pkg::*;
#(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input  logic          clk_2x,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] line_num,
  input  logic [HW-1:0] h_start,
  input  logic [HW-1:0] h_end,
  input  logic [VW-1:0] v_start,
  input  logic [VW-1:0] v_end,
  input  logic          edge_sel,
  output logic          blank_n
);

  localparam int unsigned LAG = CLKS_PER_STEP;

  logic           h_open;
  logic           v_closed;
  logic           active;
  logic [LAG-1:0] dly_q, dly_d;
  logic           out_q, out_d;
  edge_mode_e     mode;

  assign mode = edge_mode_e'(edge_sel);

  always_comb begin
    h_open = (h_start < h_end) && (hcount >= h_start) && (hcount < h_end);
    if (v_start <= v_end) begin
      v_closed = (line_num >= v_start) && (line_num < v_end);
    end else begin
      v_closed = (line_num >= v_start) || (line_num < v_end);
    end
    active = h_open && !v_closed;
  end

  // Delay line of one pixel clock for the late edge mode.
  generate
    if (LAG == 1) begin : g_lag1
      assign dly_d = active;
    end else begin : g_lagn
      assign dly_d = {dly_q[LAG-2:0], active};
    end
  endgenerate

  always_comb begin
    out_d = (mode == EDGE_LATE) ? dly_q[LAG-1] : active;
  end

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      out_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
      out_q <= out_d;
    end
  end

  assign blank_n = out_q;

endmodule

// File: rtl/blank_timing_gen.sv
module blank_timing_gen #(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input  logic          clk_2x,
  input  logic          rst_n,
  input  logic          sync_ref,
  input  logic          edge_sel,
  input  logic [HW-1:0] h_start,
  input  logic [HW-1:0] h_end,
  input  logic [VW-1:0] v_start,
  input  logic [VW-1:0] v_end,
  input  logic [VW-1:0] lines_per_field,
  output logic          blank_n,
  output logic [VW-1:0] line_num,
  output logic          field
);

  logic [HW-1:0] hcount;

  bt_hcount #(.HW(HW)) hcnt_i (
    .clk_2x   (clk_2x),
    .rst_n    (rst_n),
    .sync_ref (sync_ref),
    .hcount   (hcount)
  );

  bt_linecnt #(.VW(VW)) lcnt_i (
    .clk_2x          (clk_2x),
    .rst_n           (rst_n),
    .sync_ref        (sync_ref),
    .lines_per_field (lines_per_field),
    .line_num        (line_num),
    .field           (field)
  );

  bt_decide #(.HW(HW), .VW(VW)) dec_i (
    .clk_2x   (clk_2x),
    .rst_n    (rst_n),
    .hcount   (hcount),
    .line_num (line_num),
    .h_start  (h_start),
    .h_end    (h_end),
    .v_start  (v_start),
    .v_end    (v_end),
    .edge_sel (edge_sel),
    .blank_n  (blank_n)
  );

endmodule

// File: rtl/blank_timing_chk.sv
module blank_timing_chk #(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input logic          clk_2x,
  input logic          rst_n,
  input logic          sync_ref,
  input logic [HW-1:0] h_start,
  input logic [HW-1:0] h_end,
  input logic [VW-1:0] lines_per_field,
  input logic          blank_n,
  input logic [VW-1:0] line_num,
  input logic          field
);

  logic inv_win;
  logic at_last;

  assign inv_win = (h_start >= h_end);
  assign at_last = (line_num == lines_per_field - 1'b1);

  // R9: step on a pulse when not at the last line
  a_r9_line_steps: assert property (@(posedge clk_2x) disable iff (!rst_n)
    (sync_ref && !at_last) |=> (line_num == $past(line_num) + 1'b1) && $stable(field));

  // R9: wrap and field toggle at the last line
  a_r9_field_wrap: assert property (@(posedge clk_2x) disable iff (!rst_n)
    (sync_ref && at_last) |=> (line_num == '0) && (field != $past(field)));

  // R9: nothing moves between pulses
  a_r9_hold: assert property (@(posedge clk_2x) disable iff (!rst_n)
    !sync_ref |=> $stable(line_num) && $stable(field));

  // R5: an empty window keeps the strobe low
  a_r5_empty_window: assert property (@(posedge clk_2x) disable iff (!rst_n)
    ($past(inv_win) && $past(inv_win, 2) && $past(inv_win, 3) && $past(inv_win, 4))
      |-> !blank_n);

endmodule

bind blank_timing_gen blank_timing_chk #(.HW(HW), .VW(VW)) chk_i (
  .clk_2x          (clk_2x),
  .rst_n           (rst_n),
  .sync_ref        (sync_ref),
  .h_start         (h_start),
  .h_end           (h_end),
  .lines_per_field (lines_per_field),
  .blank_n         (blank_n),
  .line_num        (line_num),
  .field           (field)
);

// File: tb/blank_timing_gen_tb_top.sv
module blank_timing_gen_tb_top;

  localparam int HW = 11;
  localparam int VW = 10;
  localparam int LINE_CLKS = 40;

  logic          clk_2x = 1'b0;
  logic          rst_n;
  logic          sync_ref;
  logic          edge_sel;
  logic [HW-1:0] h_start, h_end;
  logic [VW-1:0] v_start, v_end, lines_per_field;
  logic          blank_n;
  logic [VW-1:0] line_num;
  logic          field;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int m_line;
  bit m_field;

  always #5 clk_2x = ~clk_2x;

  blank_timing_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk_2x          (clk_2x),
    .rst_n           (rst_n),
    .sync_ref        (sync_ref),
    .edge_sel        (edge_sel),
    .h_start         (h_start),
    .h_end           (h_end),
    .v_start         (v_start),
    .v_end           (v_end),
    .lines_per_field (lines_per_field),
    .blank_n         (blank_n),
    .line_num        (line_num),
    .field           (field)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit vblanked(input int ln);
    if (v_start <= v_end) return (ln >= v_start) && (ln < v_end);
    return (ln >= v_start) || (ln < v_end);
  endfunction

  task automatic do_reset(input int hs, input int he, input int vs, input int ve,
                          input int lpf, input bit sel);
    @(negedge clk_2x);
    rst_n = 1'b0;
    sync_ref = 1'b0;
    h_start = HW'(hs); h_end = HW'(he);
    v_start = VW'(vs); v_end = VW'(ve);
    lines_per_field = VW'(lpf);
    edge_sel = sel;
    @(negedge clk_2x);
    check("R1 blank_n in reset", int'(blank_n), 0);
    @(negedge clk_2x);
    rst_n = 1'b1;
    @(negedge clk_2x);
    m_line = 0;
    m_field = 1'b0;
  endtask

  // One line: pulse, then check every clock against the count model.
  task automatic run_line(input string tag);
    int hc, exp;
    @(negedge clk_2x);
    sync_ref = 1'b1;
    @(negedge clk_2x);
    sync_ref = 1'b0;
    if (m_line == lines_per_field - 1) begin
      m_line = 0;
      m_field = ~m_field;
    end else begin
      m_line++;
    end
    check({"R9 line_num ", tag}, int'(line_num), m_line);
    check({"R9 field ", tag}, int'(field), int'(m_field));
    for (int n = 1; n < LINE_CLKS; n++) begin
      @(negedge clk_2x);
      if (n >= 4) begin
        hc  = (n - 1 - 2 * int'(edge_sel)) / 2;
        exp = int'((h_start < h_end) && (hc >= h_start) && (hc < h_end) &&
                   !vblanked(m_line));
        check(tag, int'(blank_n), exp);
      end
    end
  endtask

  task automatic t_reset_state();
    do_reset(5, 15, 0, 0, 6, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_2x);
      check("R1 blank_n after release", int'(blank_n), 0);
    end
    check("R1 line_num", int'(line_num), 0);
    check("R1 field", int'(field), 0);
  endtask

  task automatic t_basic_window();
    int rise, fall;
    do_reset(5, 15, 0, 0, 6, 1'b0);
    // R2 R3 R4: explicit edge positions, then full-line model
    @(negedge clk_2x); sync_ref = 1'b1;
    @(negedge clk_2x); sync_ref = 1'b0;
    m_line = 1;
    rise = -1; fall = -1;
    for (int n = 1; n < LINE_CLKS; n++) begin
      @(negedge clk_2x);
      if (blank_n && rise < 0) rise = n;
      if (!blank_n && rise >= 0 && fall < 0) fall = n;
    end
    check("R2 R3 rise sample index", rise, 2 * 5 + 1);
    check("R4 fall sample index", fall, 2 * 15 + 1);
    // R10: v_start == v_end, every line open; R9 wrap past 6 lines
    for (int l = 0; l < 8; l++) run_line("R3 R4 R10 basic window");
  endtask

  task automatic t_late_edge();
    do_reset(3, 12, 0, 0, 6, 1'b1);
    for (int l = 0; l < 3; l++) run_line("R8 late edge");
  endtask

  task automatic t_empty_window();
    do_reset(15, 5, 0, 0, 6, 1'b0);
    for (int l = 0; l < 2; l++) run_line("R5 start after end");
    do_reset(9, 9, 0, 0, 6, 1'b1);
    for (int l = 0; l < 2; l++) run_line("R5 start equals end");
  endtask

  task automatic t_vblank_plain();
    do_reset(4, 16, 2, 4, 6, 1'b0);
    for (int l = 0; l < 7; l++) run_line("R6 plain vertical range");
  endtask

  task automatic t_vblank_wrap();
    do_reset(4, 16, 4, 1, 6, 1'b0);
    for (int l = 0; l < 13; l++) run_line("R7 wrapped vertical range");
  endtask

  initial begin
    rst_n = 1'b0;
    sync_ref = 1'b0;
    edge_sel = 1'b0;
    h_start = '0; h_end = '0;
    v_start = '0; v_end = '0;
    lines_per_field = VW'(6);
    t_reset_state();
    t_basic_window();
    t_late_edge();
    t_empty_window();
    t_vblank_plain();
    t_vblank_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_2x);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule